// File: doc/BRIEF.md
# Direct-Mapped Word Cache Controller

This block sits between a processor that issues 15-bit word addresses and a main memory of 32K twelve-bit words. It keeps 512 one-word lines. The upper six address bits form the tag and the lower nine bits select the line. Each line also carries a valid flag and a modified flag. A request is accepted when `cpu_busy` is low. A read hit answers one cycle later. A miss fetches the word from main memory through a request/ready handshake, returns it, and installs it in the line.

Writes follow the policy chosen by `wb_mode`. With `wb_mode` low (write-through), every write goes to main memory. A write hit also updates the line. A write miss leaves the cache untouched. With `wb_mode` high (write-back), a write stays in the cache and marks the line modified. A modified line is copied back to memory before another address takes its place. A one-cycle `inval` pulse empties the whole cache. Two counters report how many accepted requests hit and how many missed.

Top module: `cache_dm_ctrl`

## Requirements
- R1: The tag is `cpu_addr[14:9]` and the line index is `cpu_addr[8:0]`. After reset every line is empty, so the first read of an address is a miss that reads main memory at exactly that address.
- R2: A read that hits raises `cpu_done` with the stored word on `cpu_rdata` in the cycle after acceptance, with no main-memory request.
- R3: On a read miss, `mem_req` is held with `mem_we`=0 and a stable `mem_addr` until `mem_ready`. `cpu_busy` stays high meanwhile. `cpu_done` and the fetched word appear in the cycle after `mem_ready`, and a later read of that address hits.
- R4: A read whose tag differs from the tag stored at its index is a miss, even if the line is valid (octal 02000 after 00000 has been loaded). The read returns the memory word and replaces the line.
- R5: With `wb_mode`=0, a write hit updates the line and issues one memory write (`mem_we`=1) of `cpu_wdata` to `cpu_addr`.
- R6: With `wb_mode`=0, a write miss issues one memory write and no memory read. The line keeps its previous contents.
- R7: With `wb_mode`=1, a write hit completes in the cycle after acceptance without any memory traffic. Later reads return the new word.
- R8: Replacing a modified line first writes its stored word to the address {stored tag, index}. Only after that write is the memory read for the new address issued.
- R9: With `wb_mode`=1, a write miss installs the word as a modified line without reading memory. A modified victim is first written back.
- R10: `inval` empties every line in one cycle and discards modified data without writing it back. While `inval` is high, `cpu_busy` is high and no request is accepted.
- R11: `hit_count` and `miss_count` reset to zero. Each accepted request increments exactly one of them.
- R12: After reset, `cpu_busy`, `cpu_done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through, sampled when a request is accepted |
| inval | input | 1 | Empty all lines |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address |
| cpu_wdata | input | 12 | Write word |
| cpu_busy | output | 1 | Request not accepted this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 12 | Read word, valid with `cpu_done` on reads |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write |
| mem_addr | output | 15 | Main-memory word address |
| mem_wdata | output | 12 | Main-memory write word |
| mem_ready | input | 1 | Main memory completes the transfer this cycle |
| mem_rdata | input | 12 | Main-memory read word |
| hit_count | output | 16 | Accepted requests that hit |
| miss_count | output | 16 | Accepted requests that missed |

## Verification
Emptying the cache and accepting a request can fall in the same idle cycle. The bench raises `inval` together with a read of a line that holds a modified word. It then judges the result at the ports: `cpu_busy` must be high in that cycle and the miss counter must not move. Once `inval` drops, the same read must be accepted as a miss, fetch memory's word and issue no write-back. A second collision is an eviction write immediately followed by the fill read. That order is judged from the responder's log of the first transfer, its address and its data.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int CACHE_ADDR_W = 15;
    localparam int CACHE_IDX_W  = 9;
    localparam int CACHE_DATA_W = 12;
    localparam int CACHE_CNT_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WTHRU = 2'd3
    } cstate_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 6,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid;
    logic [LINES-1:0] dirty;

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = valid[rd_idx];
    assign rd_dirty = dirty[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            dirty <= '0;
        end else if (inval) begin
            valid <= '0;
            dirty <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
            dirty[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inval) tag_mem[wr_idx] <= wr_tag;
    end

    p_inval_empties_r10: assert property (@(posedge clk) disable iff (rst)
        inval |=> (valid == '0) && (dirty == '0))
        else $error("R10: lines still valid after invalidate");
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 12,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] words [LINES];

    assign rd_data = words[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/cache_ctrl_fsm.sv
module cache_ctrl_fsm
    import cache_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int IDX_W  = 9,
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_mode,
    input  logic              inval,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_valid,
    input  logic              lk_dirty,
    input  logic [DATA_W-1:0] lk_data,
    output logic              line_we,
    output logic [TAG_W-1:0]  line_tag,
    output logic              line_dirty,
    output logic [DATA_W-1:0] line_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    cstate_e           state;
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic [CNT_W-1:0]  hits, misses;

    logic [ADDR_W-1:0] sel_addr;
    logic              accept, hit, victim_dirty, idle_done;
    cstate_e           nxt_idle;

    assign sel_addr     = (state == ST_IDLE) ? cpu_addr : q_addr;
    assign lk_idx       = sel_addr[IDX_W-1:0];
    assign line_tag     = sel_addr[ADDR_W-1:IDX_W];
    assign accept       = (state == ST_IDLE) && cpu_req && !inval;
    assign hit          = lk_valid && (lk_tag == cpu_addr[ADDR_W-1:IDX_W]);
    assign victim_dirty = lk_valid && lk_dirty;

    always_comb begin
        line_we    = 1'b0;
        line_dirty = 1'b0;
        line_data  = q_wdata;
        nxt_idle   = ST_IDLE;
        idle_done  = 1'b0;
        case (state)
            ST_IDLE: if (accept) begin
                if (!cpu_we) begin
                    if (hit)               idle_done = 1'b1;
                    else if (victim_dirty) nxt_idle  = ST_EVICT;
                    else                   nxt_idle  = ST_FILL;
                end else if (wb_mode) begin
                    if (hit || !victim_dirty) begin
                        line_we    = 1'b1;
                        line_dirty = 1'b1;
                        line_data  = cpu_wdata;
                        idle_done  = 1'b1;
                    end else begin
                        nxt_idle = ST_EVICT;
                    end
                end else begin
                    if (hit) begin
                        line_we   = 1'b1;
                        line_data = cpu_wdata;
                    end
                    nxt_idle = ST_WTHRU;
                end
            end
            ST_EVICT: if (mem_ready && q_we) begin
                line_we    = 1'b1;
                line_dirty = 1'b1;
                line_data  = q_wdata;
            end
            ST_FILL: if (mem_ready) begin
                line_we   = 1'b1;
                line_data = mem_rdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            q_we    <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
            hits    <= '0;
            misses  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    q_we    <= cpu_we;
                    q_addr  <= cpu_addr;
                    q_wdata <= cpu_wdata;
                    if (hit) hits   <= hits + 1'b1;
                    else     misses <= misses + 1'b1;
                    if (!cpu_we && hit) rdata_q <= lk_data;
                    done_q <= idle_done;
                    state  <= nxt_idle;
                end
                ST_EVICT: if (mem_ready) begin
                    if (q_we) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_FILL;
                    end
                end
                ST_FILL: if (mem_ready) begin
                    done_q  <= 1'b1;
                    rdata_q <= mem_rdata;
                    state   <= ST_IDLE;
                end
                ST_WTHRU: if (mem_ready) begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cpu_busy   = (state != ST_IDLE) || inval;
    assign cpu_done   = done_q;
    assign cpu_rdata  = rdata_q;
    assign mem_req    = (state != ST_IDLE);
    assign mem_we     = (state == ST_EVICT) || (state == ST_WTHRU);
    assign mem_addr   = (state == ST_EVICT) ? {lk_tag, q_addr[IDX_W-1:0]} : q_addr;
    assign mem_wdata  = (state == ST_EVICT) ? lk_data : q_wdata;
    assign hit_count  = hits;
    assign miss_count = misses;

    p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && cpu_busy)
        else $error("R3: memory request changed before ready");

    p_done_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !mem_req)
        else $error("R2: completion while memory still requested");

    p_wb_hit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_we && wb_mode && hit) |=> !mem_req && cpu_done)
        else $error("R7: write-back hit touched memory");

    p_evict_then_fill_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EVICT && mem_ready && !q_we) |=> mem_req && !mem_we)
        else $error("R8: fill read did not follow eviction");

    p_count_one_r11: assert property (@(posedge clk) disable iff (rst)
        accept |=> ($countones({hits != $past(hits), misses != $past(misses)}) == 1))
        else $error("R11: counters did not step by exactly one");
endmodule

// File: rtl/cache_dm_ctrl.sv
module cache_dm_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = CACHE_ADDR_W,
    parameter int IDX_W  = CACHE_IDX_W,
    parameter int DATA_W = CACHE_DATA_W,
    parameter int CNT_W  = CACHE_CNT_W,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_mode,
    input  logic              inval,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_valid, lk_dirty;
    logic [DATA_W-1:0] lk_data;
    logic              line_we, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;

    cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .inval(inval),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_valid(lk_valid), .rd_dirty(lk_dirty),
        .wr_en(line_we), .wr_idx(lk_idx), .wr_tag(line_tag), .wr_dirty(line_dirty)
    );

    cache_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rd_idx(lk_idx), .rd_data(lk_data),
        .wr_en(line_we), .wr_idx(lk_idx), .wr_data(line_data)
    );

    cache_ctrl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .wb_mode(wb_mode), .inval(inval),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
        .lk_data(lk_data), .line_we(line_we), .line_tag(line_tag),
        .line_dirty(line_dirty), .line_data(line_data),
        .hit_count(hit_count), .miss_count(miss_count)
    );
endmodule

// File: tb/cache_dm_ctrl_tb.sv
module cache_dm_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_mode = 1'b0, inval = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [11:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [11:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [11:0] mem_rdata = '0;
    logic [15:0] hit_count, miss_count;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    cache_dm_ctrl u_dut (
        .clk(clk), .rst(rst), .wb_mode(wb_mode), .inval(inval),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // sparse main-memory model: written words, otherwise a computed pattern
    logic [11:0] wmem [int];
    function automatic logic [11:0] base_word(int a);
        return 12'((a * 13) ^ (a >> 4) ^ 12'h3C5);
    endfunction
    function automatic logic [11:0] model_rd(int a);
        if (wmem.exists(a)) return wmem[a];
        return base_word(a);
    endfunction

    int          rcnt = 0, n_rd = 0, n_wr = 0, n_ops = 0;
    logic        first_we = 1'b0;
    logic [14:0] last_waddr = '0, last_raddr = '0;
    logic [11:0] last_wdata = '0;

    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            rcnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            rcnt = 0;
        end else if (mem_req) begin
            rcnt++;
            if (rcnt >= MEM_LAT) begin
                mem_ready = 1'b1;
                if (n_ops == 0) first_we = mem_we;
                n_ops++;
                if (mem_we) begin
                    wmem[int'(mem_addr)] = mem_wdata;
                    n_wr++;
                    last_waddr = mem_addr;
                    last_wdata = mem_wdata;
                end else begin
                    mem_rdata = model_rd(int'(mem_addr));
                    n_rd++;
                    last_raddr = mem_addr;
                end
            end
        end
    end

    task automatic chk_eq(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [14:0] a, input logic [11:0] wd,
                          input bit exp_hit, output logic [11:0] rd, output int lat);
        int h0, m0;
        @(negedge clk); #1;
        n_rd = 0; n_wr = 0; n_ops = 0;
        h0 = int'(hit_count);
        m0 = int'(miss_count);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        while (cpu_busy) begin @(negedge clk); #2; end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        lat = 1;
        while (!cpu_done && lat < 64) begin @(negedge clk); #1; lat++; end
        rd = cpu_rdata;
        chk_eq("R11", "hit count step", int'(hit_count) - h0, exp_hit ? 1 : 0);
        chk_eq("R11", "miss count step", int'(miss_count) - m0, exp_hit ? 0 : 1);
    endtask

    task automatic t_reset();
        chk_eq("R12", "busy after reset", int'(cpu_busy), 0);
        chk_eq("R12", "done after reset", int'(cpu_done), 0);
        chk_eq("R12", "mem_req after reset", int'(mem_req), 0);
        chk_eq("R11", "counters after reset", int'(hit_count) + int'(miss_count), 0);
    endtask

    task automatic t_miss_then_hit();
        logic [11:0] rd; int lat;
        wb_mode = 1'b0;
        access(1'b0, 15'o00000, '0, 1'b0, rd, lat);
        chk_eq("R1", "first read memory reads", n_rd, 1);
        chk_eq("R1", "first read memory address", int'(last_raddr), 0);
        chk_eq("R3", "miss data", int'(rd), int'(base_word(0)));
        chk_eq("R3", "miss latency", lat, MEM_LAT + 1);
        access(1'b0, 15'o00000, '0, 1'b1, rd, lat);
        chk_eq("R2", "hit data", int'(rd), int'(base_word(0)));
        chk_eq("R2", "hit latency", lat, 1);
        chk_eq("R2", "hit memory traffic", n_ops, 0);
    endtask

    task automatic t_conflict();
        logic [11:0] rd; int lat;
        access(1'b0, 15'o02000, '0, 1'b0, rd, lat);
        chk_eq("R4", "conflict miss data", int'(rd), int'(base_word('o2000)));
        chk_eq("R4", "conflict memory address", int'(last_raddr), 'o2000);
        access(1'b0, 15'o00000, '0, 1'b0, rd, lat);
        chk_eq("R4", "replaced line misses again", int'(rd), int'(base_word(0)));
    endtask

    task automatic t_wt_write_hit();
        logic [11:0] rd; int lat;
        wb_mode = 1'b0;
        access(1'b1, 15'o00000, 12'hABC, 1'b1, rd, lat);
        chk_eq("R5", "memory writes", n_wr, 1);
        chk_eq("R5", "write address", int'(last_waddr), 0);
        chk_eq("R5", "write data", int'(last_wdata), 'hABC);
        access(1'b0, 15'o00000, '0, 1'b1, rd, lat);
        chk_eq("R5", "cache updated", int'(rd), 'hABC);
    endtask

    task automatic t_wt_write_miss();
        logic [11:0] rd; int lat;
        access(1'b1, 15'o02000, 12'h123, 1'b0, rd, lat);
        chk_eq("R6", "memory writes", n_wr, 1);
        chk_eq("R6", "memory reads", n_rd, 0);
        access(1'b0, 15'o00000, '0, 1'b1, rd, lat);
        chk_eq("R6", "line kept", int'(rd), 'hABC);
        access(1'b0, 15'o02000, '0, 1'b0, rd, lat);
        chk_eq("R6", "memory holds written word", int'(rd), 'h123);
    endtask

    task automatic t_wb_write_hit();
        logic [11:0] rd; int lat;
        wb_mode = 1'b1;
        access(1'b1, 15'o02000, 12'h456, 1'b1, rd, lat);
        chk_eq("R7", "no memory traffic", n_ops, 0);
        chk_eq("R7", "latency", lat, 1);
        access(1'b0, 15'o02000, '0, 1'b1, rd, lat);
        chk_eq("R7", "read back", int'(rd), 'h456);
        chk_eq("R7", "memory untouched", int'(model_rd('o2000)), 'h123);
    endtask

    task automatic t_wb_evict();
        logic [11:0] rd; int lat;
        access(1'b0, 15'o00000, '0, 1'b0, rd, lat);
        chk_eq("R8", "first transfer is write", int'(first_we), 1);
        chk_eq("R8", "victim address", int'(last_waddr), 'o2000);
        chk_eq("R8", "victim data", int'(last_wdata), 'h456);
        chk_eq("R8", "fill reads", n_rd, 1);
        chk_eq("R8", "fill data", int'(rd), 'hABC);
    endtask

    task automatic t_wb_write_miss();
        logic [11:0] rd; int lat;
        access(1'b1, 15'o00005, 12'h111, 1'b0, rd, lat);
        chk_eq("R9", "clean allocate traffic", n_ops, 0);
        access(1'b1, 15'o04005, 12'h222, 1'b0, rd, lat);
        chk_eq("R9", "victim written", n_wr, 1);
        chk_eq("R1", "same index victim address", int'(last_waddr), 'o00005);
        chk_eq("R9", "victim data", int'(last_wdata), 'h111);
        chk_eq("R9", "no fill read", n_rd, 0);
        access(1'b0, 15'o04005, '0, 1'b1, rd, lat);
        chk_eq("R9", "allocated word", int'(rd), 'h222);
    endtask

    task automatic t_inval();
        logic [11:0] rd; int lat, m0;
        @(negedge clk); #1;
        n_rd = 0; n_wr = 0; n_ops = 0;
        m0 = int'(miss_count);
        inval = 1'b1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 15'o04005;
        #1;
        chk_eq("R10", "busy during invalidate", int'(cpu_busy), 1);
        @(posedge clk);
        @(negedge clk); #1;
        chk_eq("R10", "request held off", int'(miss_count) - m0, 0);
        inval = 1'b0;
        #1;
        chk_eq("R10", "busy after invalidate", int'(cpu_busy), 0);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        lat = 1;
        while (!cpu_done && lat < 64) begin @(negedge clk); #1; lat++; end
        chk_eq("R10", "miss after invalidate", int'(miss_count) - m0, 1);
        chk_eq("R10", "dirty word discarded", n_wr, 0);
        chk_eq("R10", "memory word returned", int'(cpu_rdata), int'(base_word('o4005)));
        access(1'b0, 15'o00000, '0, 1'b0, rd, lat);
        chk_eq("R10", "other line emptied", int'(rd), 'hABC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_miss_then_hit();
        t_conflict();
        t_wt_write_hit();
        t_wt_write_miss();
        t_wb_write_hit();
        t_wb_evict();
        t_wb_write_miss();
        t_inval();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule